// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block holds eight wide floating-point values, each with a 2-bit tag, in a circular register file. The file can be used as a stack or addressed directly. A 3-bit top pointer names the physical slot that is the current top of the stack. A push moves the pointer down by one before it stores a value. A pop returns the top value and then moves the pointer up by one. Direct reads and writes name a slot by its distance from the top. The block does no arithmetic. It treats each value as an opaque 80-bit word, except that it inspects the exponent and significand fields to work out the tag when the value is written.

The tags, not the data, decide whether a slot is free. Stack faults are detected from the tags: a push into an occupied slot is an overflow, and a pop or read of a free slot is an underflow. All eight tags are packed into one 16-bit word so that software or exception logic can find free slots without decoding any data. A synchronous init input empties the whole file in one cycle.

Only one operation is accepted per cycle. Results of pops and reads, and the fault flags, are registered, so they appear in the cycle after the request. The pointer and the tag word always show the current state.

Top module: `fpreg_stack`

## Requirements
- R1: After reset, `top` is 0, `tag_word` is 16'hFFFF (every slot empty), and `rd_valid`, `stk_ovf` and `stk_unf` are 0.
- R2: A push (`op`=1) into an empty slot first sets `top` to (`top`-1) mod 8, then stores `wr_data` in that slot. From 0 the pointer wraps to 7.
- R3: A push whose target slot (`top`-1) mod 8 does not have the empty tag pulses `stk_ovf` in the next cycle. It leaves `top`, every tag and every stored value unchanged.
- R4: A pop (`op`=2) of a non-empty top slot raises `rd_valid` in the next cycle, with that slot's value and tag. It then sets that slot's tag to empty and sets `top` to (`top`+1) mod 8.
- R5: A pop, or a read, whose addressed slot has the empty tag pulses `stk_unf` in the next cycle and keeps `rd_valid` low. It leaves `top` and the tags unchanged.
- R6: A read (`op`=3) of ST(i), where i is `idx`, addresses physical slot (`top`+i) mod 8. It returns the value and tag of that slot in the next cycle and changes no state.
- R7: A write (`op`=4) stores `wr_data` in slot (`top`+`idx`) mod 8, whatever that slot's previous tag. The slot's tag is recomputed from the new value, and `top` does not change.
- R8: The tag is computed from the value as it is written. The value is laid out as sign in bit 79, exponent in bits 78:64 and significand in bits 63:0. The tag is 2'b11 for empty, 2'b01 for zero (exponent 0 and significand 0), and 2'b10 for special (exponent all ones, or exponent 0 with a non-zero significand). Every other value gets 2'b00, valid.
- R9: `tag_word` bits [2k+1:2k] hold the tag of physical slot k at all times.
- R10: An `init` pulse sets `top` to 0 and every tag to empty in one cycle. It clears the registered outputs and takes priority over any `op` given in the same cycle.
- R11: Opcodes 0 (no-op), 5, 6 and 7 change no state and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Synchronous clear of pointer and tags |
| op | input | 3 | Operation: 0 none, 1 push, 2 pop, 3 read, 4 write |
| idx | input | 3 | Stack-relative index i for read and write |
| wr_data | input | 80 | Value for push and write |
| rd_valid | output | 1 | Registered: a pop or read returned data |
| rd_data | output | 80 | Registered value from a pop or read |
| rd_tag | output | 2 | Registered tag from a pop or read |
| stk_ovf | output | 1 | Registered overflow pulse |
| stk_unf | output | 1 | Registered underflow pulse |
| top | output | 3 | Current top-of-stack physical slot |
| tag_word | output | 16 | All eight tags, slot k in bits [2k+1:2k] |

## Verification
The bench builds the block with its default parameters: eight slots, a 15-bit exponent and a 64-bit significand. With eight slots, nine pushes are enough to wrap the pointer all the way round and reach an overflow, and nine pops are enough to reach an underflow. The 80-bit layout lets the bench give zero, infinity, NaN, denormal and normal values to the tag logic. Every cycle is compared against a reference model of the pointer and tags, so the tag word is checked after every operation.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_READ  = 3'd3,
    OP_WRITE = 3'd4
  } op_e;

endpackage

// File: rtl/fpstk_tagger.sv
module fpstk_tagger
  import fpstk_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic [DATA_W-1:0] value,
  output tag_e              tag
);

  function automatic tag_e classify(input logic [EXP_W-1:0] e, input logic [MAN_W-1:0] m);
    if (&e)                   return TAG_SPECIAL;
    else if (e == '0)         return (m == '0) ? TAG_ZERO : TAG_SPECIAL;
    else                      return TAG_VALID;
  endfunction

  assign tag = classify(value[DATA_W-2 -: EXP_W], value[MAN_W-1:0]);

endmodule

// File: rtl/fpstk_ptr.sv
module fpstk_ptr #(
  parameter int NREG = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dec,
  input  logic             inc,
  input  logic [IDX_W-1:0] rel,
  output logic [IDX_W-1:0] top,
  output logic [IDX_W-1:0] below,
  output logic [IDX_W-1:0] rel_phys
);

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b);
    logic [IDX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s >= NREG[IDX_W:0]) ? IDX_W'(s - NREG[IDX_W:0]) : s[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] wrap_dec(input logic [IDX_W-1:0] a);
    return (a == '0) ? IDX_W'(NREG - 1) : a - 1'b1;
  endfunction

  logic [IDX_W-1:0] top_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_q <= '0;
    else if (clr)    top_q <= '0;
    else if (dec)    top_q <= wrap_dec(top_q);
    else if (inc)    top_q <= wrap_add(top_q, IDX_W'(1));
  end

  assign top      = top_q;
  assign below    = wrap_dec(top_q);
  assign rel_phys = wrap_add(top_q, rel);

  a_r2_push_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !clr) |=> (top_q == $past(below)));
  a_r4_pop_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !clr) |=> (below == $past(top_q)));
  a_r10_clear_top: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (top_q == '0));

endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile
  import fpstk_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DATA_W = 80,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               we,
  input  logic [IDX_W-1:0]   wa,
  input  logic [DATA_W-1:0]  wd,
  input  tag_e               wt,
  input  logic               vac,
  input  logic [IDX_W-1:0]   va,
  input  logic [IDX_W-1:0]   ra,
  output logic [DATA_W-1:0]  rd,
  output tag_e               rt,
  input  logic [IDX_W-1:0]   pa,
  output tag_e               pt,
  output logic [2*NREG-1:0]  tag_flat
);

  logic [DATA_W-1:0] data_q [NREG];
  tag_e              tag_q  [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_slot
    logic hit_w, hit_v;
    assign hit_w = we  && (wa == IDX_W'(k));
    assign hit_v = vac && (va == IDX_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[k] <= '0;
        tag_q[k]  <= TAG_EMPTY;
      end else if (clr) begin
        tag_q[k]  <= TAG_EMPTY;
      end else if (hit_w) begin
        data_q[k] <= wd;
        tag_q[k]  <= wt;
      end else if (hit_v) begin
        tag_q[k]  <= TAG_EMPTY;
      end
    end

    assign tag_flat[2*k +: 2] = tag_q[k];
  end

  assign rd = data_q[ra];
  assign rt = tag_q[ra];
  assign pt = tag_q[pa];

  a_r4_vacated_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (vac && !clr && !we) |=> (tag_q[$past(va)] == TAG_EMPTY));
  a_r10_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (&tag_flat));
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (data_q[$past(wa)] == $past(wd)));

endmodule

// File: rtl/fpreg_stack.sv
module fpreg_stack
  import fpstk_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int DATA_W = 1 + EXP_W + MAN_W,
  localparam int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [2:0]        op,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_tag,
  output logic              stk_ovf,
  output logic              stk_unf,
  output logic [IDX_W-1:0]  top,
  output logic [2*NREG-1:0] tag_word
);

  logic [IDX_W-1:0]  top_w, below_w, rel_w, src_idx, wa_w;
  logic [DATA_W-1:0] src_data;
  tag_e              src_tag, below_tag, new_tag;

  logic is_push, is_pop, is_read, is_write, is_fetch;
  logic push_ok, push_ovf, fetch_ok, fetch_unf, wr_en, pop_ok;

  assign is_push  = !init && (op == OP_PUSH);
  assign is_pop   = !init && (op == OP_POP);
  assign is_read  = !init && (op == OP_READ);
  assign is_write = !init && (op == OP_WRITE);
  assign is_fetch = is_pop || is_read;

  assign src_idx  = is_pop ? top_w : rel_w;

  assign push_ok   = is_push && (below_tag == TAG_EMPTY);
  assign push_ovf  = is_push && (below_tag != TAG_EMPTY);
  assign fetch_ok  = is_fetch && (src_tag != TAG_EMPTY);
  assign fetch_unf = is_fetch && (src_tag == TAG_EMPTY);
  assign pop_ok    = is_pop && fetch_ok;
  assign wr_en     = push_ok || is_write;
  assign wa_w      = push_ok ? below_w : rel_w;

  fpstk_tagger #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_tagger (
    .value (wr_data),
    .tag   (new_tag)
  );

  fpstk_ptr #(.NREG(NREG)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (init),
    .dec      (push_ok),
    .inc      (pop_ok),
    .rel      (idx),
    .top      (top_w),
    .below    (below_w),
    .rel_phys (rel_w)
  );

  fpstk_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (init),
    .we       (wr_en),
    .wa       (wa_w),
    .wd       (wr_data),
    .wt       (new_tag),
    .vac      (pop_ok),
    .va       (top_w),
    .ra       (src_idx),
    .rd       (src_data),
    .rt       (src_tag),
    .pa       (below_w),
    .pt       (below_tag),
    .tag_flat (tag_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_tag   <= TAG_EMPTY;
      stk_ovf  <= 1'b0;
      stk_unf  <= 1'b0;
    end else begin
      rd_valid <= fetch_ok;
      stk_ovf  <= push_ovf;
      stk_unf  <= fetch_unf;
      if (fetch_ok) begin
        rd_data <= src_data;
        rd_tag  <= src_tag;
      end
    end
  end

  assign top = top_w;

  a_r3_ovf_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    push_ovf |=> (stk_ovf && $stable(tag_word) && $stable(top)));
  a_r5_unf_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_unf |=> (stk_unf && !rd_valid && $stable(tag_word) && $stable(top)));
  a_r5_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_ovf, stk_unf, rd_valid}) || (rd_valid && !stk_ovf && !stk_unf));
  a_r4_valid_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_tag != TAG_EMPTY));
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && op > 3'd4) |=> ($stable(tag_word) && $stable(top) && !stk_ovf && !stk_unf && !rd_valid));

endmodule

// File: tb/fpreg_stack_test.sv
module fpreg_stack_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [2:0]  idx = 3'd0;
  logic [79:0] wr_data = '0;
  logic        rd_valid, stk_ovf, stk_unf;
  logic [79:0] rd_data;
  logic [1:0]  rd_tag;
  logic [2:0]  top;
  logic [15:0] tag_word;

  always #2.5 clk = ~clk;

  fpreg_stack uut (
    .clk(clk), .rst_n(rst_n), .init(init), .op(op), .idx(idx), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag),
    .stk_ovf(stk_ovf), .stk_unf(stk_unf), .top(top), .tag_word(tag_word)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        v;
    logic [79:0] d;
    logic [1:0]  t;
    logic        ovf;
    logic        unf;
    logic [2:0]  tp;
    logic [15:0] tw;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];

  logic [2:0]  m_top = 3'd0;
  logic [1:0]  m_tag [8];
  logic [79:0] m_dat [8];

  localparam logic [79:0] V_ONE  = 80'h3FFF_8000_0000_0000_0000;
  localparam logic [79:0] V_NEG  = 80'hC002_A000_0000_0000_0000;
  localparam logic [79:0] V_ZERO = 80'h0000_0000_0000_0000_0000;
  localparam logic [79:0] V_NZ   = 80'h8000_0000_0000_0000_0000;
  localparam logic [79:0] V_INF  = 80'h7FFF_8000_0000_0000_0000;
  localparam logic [79:0] V_NAN  = 80'hFFFF_C000_0000_0000_0001;
  localparam logic [79:0] V_DEN  = 80'h0000_0000_0000_0000_0001;
  localparam logic [79:0] V_BIG  = 80'h7FFE_FFFF_FFFF_FFFF_FFFF;

  function automatic logic [1:0] ref_tag(input logic [79:0] v);
    logic [14:0] e = v[78:64];
    logic [63:0] f = v[63:0];
    if (e == 15'h7FFF) return 2'b10;
    if (e != 15'h0000) return 2'b00;
    if (f != 64'd0)    return 2'b10;
    return 2'b01;
  endfunction

  function automatic logic [15:0] ref_word();
    logic [15:0] w = '0;
    for (int k = 0; k < 8; k++) w[2*k +: 2] = m_tag[k];
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic drive(input logic in_init, input logic [2:0] o, input logic [2:0] i,
                       input logic [79:0] d, input string req);
    exp_t e;
    logic [2:0] p;
    @(negedge clk);
    init = in_init; op = o; idx = i; wr_data = d;
    e.v = 1'b0; e.d = '0; e.t = 2'b11; e.ovf = 1'b0; e.unf = 1'b0;
    if (in_init) begin
      m_top = 3'd0;
      for (int k = 0; k < 8; k++) m_tag[k] = 2'b11;
    end else begin
      case (o)
        3'd1: begin
          p = m_top - 3'd1;
          if (m_tag[p] != 2'b11) e.ovf = 1'b1;
          else begin m_top = p; m_dat[p] = d; m_tag[p] = ref_tag(d); end
        end
        3'd2, 3'd3: begin
          p = (o == 3'd2) ? m_top : m_top + i;
          if (m_tag[p] == 2'b11) e.unf = 1'b1;
          else begin
            e.v = 1'b1; e.d = m_dat[p]; e.t = m_tag[p];
            if (o == 3'd2) begin m_tag[p] = 2'b11; m_top = m_top + 3'd1; end
          end
        end
        3'd4: begin
          p = m_top + i;
          m_dat[p] = d; m_tag[p] = ref_tag(d);
        end
        default: ;
      endcase
    end
    e.tp = m_top;
    e.tw = ref_word();
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(r, "rd_valid", 80'(rd_valid), 80'(e.v));
      if (e.v) begin
        chk(r, "rd_data", rd_data, e.d);
        chk(r, "rd_tag", 80'(rd_tag), 80'(e.t));
      end
      chk(r, "stk_ovf", 80'(stk_ovf), 80'(e.ovf));
      chk(r, "stk_unf", 80'(stk_unf), 80'(e.unf));
      chk(r, "top", 80'(top), 80'(e.tp));
      chk({r, "/R9"}, "tag_word", 80'(tag_word), 80'(e.tw));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 8; k++) begin m_tag[k] = 2'b11; m_dat[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "top", 80'(top), 80'd0);
    chk("R1", "tag_word", 80'(tag_word), 80'hFFFF);
    chk("R1", "flags", 80'({rd_valid, stk_ovf, stk_unf}), 80'd0);

    // R2 and R8: eight pushes wrap the pointer through every slot
    drive(0, 3'd1, 3'd0, V_ONE,  "R2");
    drive(0, 3'd1, 3'd0, V_ZERO, "R8");
    drive(0, 3'd1, 3'd0, V_INF,  "R8");
    drive(0, 3'd1, 3'd0, V_NAN,  "R8");
    drive(0, 3'd1, 3'd0, V_DEN,  "R8");
    drive(0, 3'd1, 3'd0, V_NZ,   "R8");
    drive(0, 3'd1, 3'd0, V_BIG,  "R8");
    drive(0, 3'd1, 3'd0, V_NEG,  "R2");
    // R3: ninth push hits an occupied slot
    drive(0, 3'd1, 3'd0, V_ONE,  "R3");
    drive(0, 3'd0, 3'd0, V_ONE,  "R3");
    // R6: stack-relative reads
    drive(0, 3'd3, 3'd0, '0, "R6");
    drive(0, 3'd3, 3'd3, '0, "R6");
    drive(0, 3'd3, 3'd7, '0, "R6");
    // R7: overwrite ST(2) and read it back
    drive(0, 3'd4, 3'd2, V_INF, "R7");
    drive(0, 3'd3, 3'd2, '0, "R7");
    // R11: unused opcodes change nothing
    drive(0, 3'd5, 3'd1, V_ONE, "R11");
    drive(0, 3'd6, 3'd2, V_ONE, "R11");
    drive(0, 3'd7, 3'd3, V_ONE, "R11");
    // R4: pop everything, then R5 underflow
    for (int n = 0; n < 8; n++) drive(0, 3'd2, 3'd5, '0, "R4");
    drive(0, 3'd2, 3'd0, '0, "R5");
    drive(0, 3'd3, 3'd4, '0, "R5");
    // R7: write into an empty slot, then pop it
    drive(0, 3'd4, 3'd0, V_ZERO, "R7");
    drive(0, 3'd2, 3'd0, '0, "R4");
    // R10: init wins over a push in the same cycle
    drive(0, 3'd1, 3'd0, V_ONE, "R2");
    drive(0, 3'd1, 3'd0, V_NEG, "R2");
    drive(1, 3'd1, 3'd0, V_INF, "R10");
    drive(0, 3'd2, 3'd0, '0, "R10");
    drive(0, 3'd1, 3'd0, V_DEN, "R2");
    drive(1, 3'd2, 3'd0, '0, "R10");
    drive(0, 3'd0, 3'd0, '0, "R10");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule